// File: doc/BRIEF.md
# Signed-Count Shift and Rotate Unit

This unit is the shift stage of a small processor datapath. It takes a 16-bit operand and moves it by a signed count in one of four families: logical shift, arithmetic shift, plain rotate, and extended rotate, where the rotation runs through the X flag. The count can come from a 5-bit signed immediate or from the low five bits of a register value. A negative count reverses the direction that the operation names. The magnitude of the count can be as large as 16.

Operands are presented with `in_valid`. One clock later the result appears, together with the updated X and C flags, the zero and negative flags and, when requested, the number of set bits in the result. The outputs hold their values until the next valid operation. Instruction decode and register-file access happen outside this unit.

Top module: `shift_rotate_unit`

## Requirements
- R1: When `use_reg` is 1, the count is bits [4:0] of `reg_count`, bits [15:5] of `reg_count` are ignored, and `imm_count` is ignored. When `use_reg` is 0, the count is `imm_count`. The count is a 5-bit two's-complement value from -16 to 15.
- R2: `dir_left` = 1 names a left move and 0 names a right move. A negative count moves the other way by the magnitude of the count, so a count of -16 moves 16 places.
- R3: A count of zero returns the operand unchanged and passes `c_in` to `c_out` and `x_in` to `x_out`, in every family.
- R4: When `family` = 00 (logical), vacated bits fill with zero in both directions. C is the last bit shifted out, and X takes the same value as C.
- R5: When `family` = 01 (arithmetic), a left move behaves like the logical left move. A right move fills with copies of bit 15. C and X take the last bit shifted out.
- R6: When `family` = 10 (rotate), bits leaving one end enter the other end. After a nonzero count, C equals result bit 0 for a left rotate and result bit 15 for a right rotate. X passes through unchanged.
- R7: When `family` = 11 (extended rotate), X and the 16 operand bits form a 17-bit ring with X above bit 15. The bit that ends up in the X position becomes both `x_out` and `c_out`.
- R8: `z_out` is 1 exactly when `result` is zero. `n_out` equals `result[15]`.
- R9: With `weight_en` = 1, `weight` is the number of ones in `result` (0 to 16). With `weight_en` = 0, `weight` is 0.
- R10: All outputs are registered and update in the cycle after `in_valid`. `out_valid` follows `in_valid` by one cycle. When `in_valid` is low the data outputs hold their values. During reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request |
| operand | input | 16 | Value to shift or rotate |
| imm_count | input | 5 | Signed immediate count |
| reg_count | input | 16 | Register value; only the low 5 bits are used |
| use_reg | input | 1 | 1 selects `reg_count` as the count source |
| family | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 extended rotate |
| dir_left | input | 1 | Named direction, 1 = left |
| x_in | input | 1 | Incoming X flag |
| c_in | input | 1 | Incoming C flag |
| weight_en | input | 1 | Request the ones count |
| out_valid | output | 1 | Result valid |
| result | output | 16 | Shifted or rotated value |
| x_out | output | 1 | Updated X flag |
| c_out | output | 1 | Updated C flag |
| z_out | output | 1 | Result is zero |
| n_out | output | 1 | Result bit 15 |
| weight | output | 5 | Ones count of the result |

## Verification
The bench targets the count extremes. A count of -16 must move the operand 16 places the other way; a design that sign-extends the magnitude wrongly would move it 0 places or the wrong way. A count of 16 in the extended rotate must leave the old bit 0 in X; a 16-bit ring would return the operand with X untouched.

The bench also checks that a zero count leaves C and X alone in every family; a design that updates the flags regardless would clear C. Arithmetic right moves must fill with bit 15, rotates must keep X, and garbage in the upper register bits must not change the count. Each of these faults gives a wrong result or wrong flags that a reference model in the bench catches.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic [1:0] {
    FAM_LOGIC = 2'b00,
    FAM_ARITH = 2'b01,
    FAM_ROT   = 2'b10,
    FAM_ROTX  = 2'b11
  } family_e;
endpackage

// File: rtl/sru_count_decode.sv
module sru_count_decode #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] imm_count,
  input  logic [WIDTH-1:0] reg_count,
  input  logic             use_reg,
  input  logic             dir_left,
  output logic [CNT_W-1:0] mag,
  output logic             go_left,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] desc;
  logic             neg;

  function automatic logic [CNT_W-1:0] f_magnitude(logic [CNT_W-1:0] d);
    return d[CNT_W-1] ? (~d + CNT_W'(1)) : d;
  endfunction

  assign desc     = use_reg ? reg_count[CNT_W-1:0] : imm_count;
  assign neg      = desc[CNT_W-1];
  assign mag      = f_magnitude(desc);
  assign go_left  = dir_left ^ neg;
  assign cnt_zero = (desc == '0);
endmodule

// File: rtl/sru_shifter.sv
module sru_shifter
  import sru_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int MAG_W = 5
) (
  input  logic [WIDTH-1:0] operand,
  input  family_e          family,
  input  logic             go_left,
  input  logic [MAG_W-1:0] mag,
  input  logic             x_in,
  output logic [WIDTH-1:0] res,
  output logic             shift_out
);
  localparam int DW = 2 * WIDTH;
  localparam int RW = WIDTH + 1;

  // returns {last bit out, result}
  function automatic logic [WIDTH:0] f_shift(logic [WIDTH-1:0] a, logic left,
                                             logic [MAG_W-1:0] n, logic arith);
    logic [DW-1:0] e;
    if (left) begin
      e = {{WIDTH{1'b0}}, a} << n;
      return {e[WIDTH], e[WIDTH-1:0]};
    end
    e = {a, {WIDTH{1'b0}}};
    if (arith) e = $unsigned($signed(e) >>> n);
    else       e = e >> n;
    return {e[WIDTH-1], e[DW-1:WIDTH]};
  endfunction

  function automatic logic [WIDTH:0] f_rotate(logic [WIDTH-1:0] a, logic left,
                                              logic [MAG_W-1:0] n);
    logic [DW-1:0]    d;
    logic [WIDTH-1:0] r;
    d = {a, a};
    if (left) begin
      d = d << n;
      r = d[DW-1:WIDTH];
      return {r[0], r};
    end
    d = d >> n;
    r = d[WIDTH-1:0];
    return {r[WIDTH-1], r};
  endfunction

  // returns the new 17-bit ring {x, result}
  function automatic logic [RW-1:0] f_rotx(logic [WIDTH-1:0] a, logic x,
                                           logic left, logic [MAG_W-1:0] n);
    logic [2*RW-1:0] d;
    d = {x, a, x, a};
    if (left) begin
      d = d << n;
      return d[2*RW-1:RW];
    end
    d = d >> n;
    return d[RW-1:0];
  endfunction

  logic [WIDTH:0] pick;

  always_comb begin
    unique case (family)
      FAM_LOGIC: pick = f_shift(operand, go_left, mag, 1'b0);
      FAM_ARITH: pick = f_shift(operand, go_left, mag, 1'b1);
      FAM_ROT:   pick = f_rotate(operand, go_left, mag);
      default:   pick = f_rotx(operand, x_in, go_left, mag);
    endcase
  end

  assign res       = pick[WIDTH-1:0];
  assign shift_out = pick[WIDTH];
endmodule

// File: rtl/sru_popcount.sv
module sru_popcount #(
  parameter int WIDTH = 16,
  parameter int CW    = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CW-1:0]    ones
);
  logic [CW-1:0] acc [0:WIDTH];

  assign acc[0] = '0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign acc[i+1] = acc[i] + CW'(vec[i]);
  end
  assign ones = acc[WIDTH];
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter  int WIDTH = 16,
  parameter  int CNT_W = 5,
  localparam int WT_W  = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] operand,
  input  logic [CNT_W-1:0] imm_count,
  input  logic [WIDTH-1:0] reg_count,
  input  logic             use_reg,
  input  logic [1:0]       family,
  input  logic             dir_left,
  input  logic             x_in,
  input  logic             c_in,
  input  logic             weight_en,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             x_out,
  output logic             c_out,
  output logic             z_out,
  output logic             n_out,
  output logic [WT_W-1:0]  weight
);
  family_e          fam;
  logic [CNT_W-1:0] mag;
  logic             go_left;
  logic             cnt_zero;
  logic [WIDTH-1:0] next_res;
  logic             shift_out;
  logic             next_c;
  logic             next_x;
  logic [WT_W-1:0]  next_ones;

  assign fam = family_e'(family);

  sru_count_decode #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_dec (
    .imm_count (imm_count),
    .reg_count (reg_count),
    .use_reg   (use_reg),
    .dir_left  (dir_left),
    .mag       (mag),
    .go_left   (go_left),
    .cnt_zero  (cnt_zero)
  );

  sru_shifter #(.WIDTH(WIDTH), .MAG_W(CNT_W)) u_shf (
    .operand   (operand),
    .family    (fam),
    .go_left   (go_left),
    .mag       (mag),
    .x_in      (x_in),
    .res       (next_res),
    .shift_out (shift_out)
  );

  sru_popcount #(.WIDTH(WIDTH)) u_pop (
    .vec  (next_res),
    .ones (next_ones)
  );

  always_comb begin
    next_c = cnt_zero ? c_in : shift_out;
    next_x = (cnt_zero || fam == FAM_ROT) ? x_in : shift_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      x_out     <= 1'b0;
      c_out     <= 1'b0;
      z_out     <= 1'b0;
      n_out     <= 1'b0;
      weight    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= next_res;
        x_out  <= next_x;
        c_out  <= next_c;
        z_out  <= (next_res == '0);
        n_out  <= next_res[WIDTH-1];
        weight <= weight_en ? next_ones : '0;
      end
    end
  end
endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter  int WIDTH = 16,
  parameter  int CNT_W = 5,
  localparam int WT_W  = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [WIDTH-1:0] operand,
  input logic [1:0]       family,
  input logic             x_in,
  input logic             c_in,
  input logic             weight_en,
  input logic             cnt_zero,
  input logic             out_valid,
  input logic [WIDTH-1:0] result,
  input logic             x_out,
  input logic             c_out,
  input logic             z_out,
  input logic             n_out,
  input logic [WT_W-1:0]  weight
);
  a_r3_zero_count_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cnt_zero |=> result == $past(operand) && c_out == $past(c_in)
                             && x_out == $past(x_in));

  a_r6_rotate_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && family == 2'b10 |=>
      $countones(result) == $countones($past(operand)) && x_out == $past(x_in));

  a_r7_ring_flags_agree: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && family == 2'b11 && !cnt_zero |=> x_out == c_out);

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> z_out == (result == '0));

  a_r8_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> n_out == result[WIDTH-1]);

  a_r9_weight_on: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && weight_en |=> weight == WT_W'($countones(result)));

  a_r9_weight_off: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !weight_en |=> weight == '0);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && $past(rst_n) |=> $stable(result) && $stable(c_out) && $stable(x_out));
endmodule

bind shift_rotate_unit sru_checker #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_sru_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .operand   (operand),
  .family    (family),
  .x_in      (x_in),
  .c_in      (c_in),
  .weight_en (weight_en),
  .cnt_zero  (cnt_zero),
  .out_valid (out_valid),
  .result    (result),
  .x_out     (x_out),
  .c_out     (c_out),
  .z_out     (z_out),
  .n_out     (n_out),
  .weight    (weight)
);

// File: tb/test_shift_rotate_unit.sv
`timescale 1ns/1ps
module test_shift_rotate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] operand = '0;
  logic [4:0]  imm_count = '0;
  logic [15:0] reg_count = '0;
  logic        use_reg = 1'b0;
  logic [1:0]  family = '0;
  logic        dir_left = 1'b0;
  logic        x_in = 1'b0;
  logic        c_in = 1'b0;
  logic        weight_en = 1'b0;
  logic        out_valid;
  logic [15:0] result;
  logic        x_out, c_out, z_out, n_out;
  logic [4:0]  weight;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shift_rotate_unit i_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .imm_count(imm_count), .reg_count(reg_count), .use_reg(use_reg),
    .family(family), .dir_left(dir_left), .x_in(x_in), .c_in(c_in),
    .weight_en(weight_en), .out_valid(out_valid), .result(result),
    .x_out(x_out), .c_out(c_out), .z_out(z_out), .n_out(n_out),
    .weight(weight)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // step-by-step reference: returns {x, c, result}
  function automatic logic [17:0] model(logic [15:0] op, logic xi, logic ci,
                                        logic [1:0] fam, logic left, int n);
    logic [15:0] v = op;
    logic x = xi, c = ci, o = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (left) begin
        o = v[15];
        case (fam)
          2'b10:   v = {v[14:0], v[15]};
          2'b11:   begin v = {v[14:0], x}; x = o; end
          default: v = {v[14:0], 1'b0};
        endcase
      end else begin
        o = v[0];
        case (fam)
          2'b00:   v = {1'b0, v[15:1]};
          2'b01:   v = {v[15], v[15:1]};
          2'b10:   v = {v[0], v[15:1]};
          default: begin v = {x, v[15:1]}; x = o; end
        endcase
      end
    end
    if (n > 0) begin
      c = o;
      if (fam != 2'b10) x = o;
    end
    return {x, c, v};
  endfunction

  task automatic run_op(string req, logic [15:0] op, logic [4:0] imm,
                        logic [15:0] rc, logic ureg, logic [1:0] fam,
                        logic left, logic xi, logic ci, logic we);
    logic [4:0]  d;
    int          sd, n, ones;
    logic        eff_left;
    logic [17:0] m;
    @(negedge clk);
    operand = op; imm_count = imm; reg_count = rc; use_reg = ureg;
    family = fam; dir_left = left; x_in = xi; c_in = ci; weight_en = we;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    d  = ureg ? rc[4:0] : imm;
    sd = d[4] ? int'(d) - 32 : int'(d);
    n  = (sd < 0) ? -sd : sd;
    eff_left = (sd < 0) ? !left : left;
    m = model(op, xi, ci, fam, eff_left, n);
    ones = 0;
    for (int i = 0; i < 16; i++) ones += int'(m[i]);
    chk(req, "valid",  32'(out_valid), 32'd1);
    chk(req, "result", 32'(result), 32'(m[15:0]));
    chk(req, "c",      32'(c_out), 32'(m[16]));
    chk(req, "x",      32'(x_out), 32'(m[17]));
    chk("R8", "z",     32'(z_out), 32'(m[15:0] == 16'h0));
    chk("R8", "n",     32'(n_out), 32'(m[15]));
    chk("R9", "weight", 32'(weight), we ? 32'(ones) : 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R10", "reset outputs",
        {8'h0, out_valid, result, x_out, c_out, z_out, n_out, weight}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_logical();
    run_op("R4", 16'h8001, 5'd1, 16'h0, 0, 2'b00, 1, 0, 0, 0);
    chk("R4", "lsl fixed", 32'({c_out, result}), 32'h10002);
    run_op("R4", 16'hA5C3, 5'd4, 16'h0, 0, 2'b00, 0, 1, 0, 0);
    run_op("R4", 16'hFFFF, 5'd15, 16'h0, 0, 2'b00, 1, 0, 1, 0);
  endtask

  task automatic t_arith();
    run_op("R5", 16'h8004, 5'd3, 16'h0, 0, 2'b01, 0, 0, 0, 0);
    chk("R5", "asr fixed", 32'({c_out, result}), 32'h1F000);
    run_op("R5", 16'h4321, 5'd2, 16'h0, 0, 2'b01, 1, 0, 0, 0);
    run_op("R5", 16'h9000, 5'd15, 16'h0, 0, 2'b01, 0, 0, 0, 0);
  endtask

  task automatic t_rotate();
    run_op("R6", 16'h8001, 5'd1, 16'h0, 0, 2'b10, 1, 1, 0, 0);
    chk("R6", "rol fixed", 32'({x_out, c_out, result}), 32'h30003);
    run_op("R6", 16'h1234, 5'd4, 16'h0, 0, 2'b10, 0, 0, 0, 0);
    chk("R6", "ror fixed", 32'(result), 32'h4123);
  endtask

  task automatic t_rotx();
    run_op("R7", 16'h8000, 5'd1, 16'h0, 0, 2'b11, 1, 1, 0, 0);
    chk("R7", "roxl fixed", 32'({x_out, result}), 32'h10001);
    run_op("R7", 16'h0001, 5'd1, 16'h0, 0, 2'b11, 0, 0, 0, 0);
    run_op("R7", 16'hC3A5, 5'd15, 16'h0, 0, 2'b11, 1, 1, 0, 0);
  endtask

  task automatic t_negative();
    run_op("R2", 16'h00F0, 5'b11111, 16'h0, 0, 2'b00, 1, 0, 0, 0);
    chk("R2", "-1 left is right", 32'(result), 32'h0078);
    run_op("R2", 16'hBEEF, 5'b10000, 16'h0, 0, 2'b11, 0, 1, 0, 0);
    run_op("R2", 16'h8421, 5'b10000, 16'h0, 0, 2'b01, 1, 0, 0, 0);
    run_op("R2", 16'h1234, 5'b10000, 16'h0, 0, 2'b10, 0, 0, 1, 0);
  endtask

  task automatic t_zero();
    for (int f = 0; f < 4; f++)
      run_op("R3", 16'h5A5A, 5'd0, 16'h0, 0, 2'(f), 1, 1, 1, 0);
    chk("R3", "zero keeps", 32'({x_out, c_out, result}), 32'h35A5A);
  endtask

  task automatic t_source();
    run_op("R1", 16'h0F0F, 5'd7, 16'hFFE3, 1, 2'b00, 1, 0, 0, 0);
    chk("R1", "reg low bits", 32'(result), 32'h7878);
    run_op("R1", 16'h0F0F, 5'd2, 16'hAB80, 0, 2'b00, 1, 0, 0, 0);
    chk("R1", "imm source", 32'(result), 32'h3C3C);
  endtask

  task automatic t_flags_weight();
    run_op("R8", 16'h0001, 5'd1, 16'h0, 0, 2'b00, 0, 0, 0, 1);
    chk("R8", "zero result", 32'(z_out), 32'd1);
    run_op("R9", 16'hFFFF, 5'd0, 16'h0, 0, 2'b10, 1, 0, 0, 1);
    chk("R9", "full weight", 32'(weight), 32'd16);
    run_op("R9", 16'hF0F0, 5'd3, 16'h0, 0, 2'b10, 1, 0, 0, 0);
  endtask

  task automatic t_hold();
    logic [15:0] keep;
    run_op("R10", 16'h1357, 5'd2, 16'h0, 0, 2'b00, 1, 0, 0, 1);
    keep = result;
    @(negedge clk);
    operand = 16'hFFFF; imm_count = 5'd5;
    @(negedge clk);
    chk("R10", "valid drops", 32'(out_valid), 32'd0);
    chk("R10", "result held", 32'(result), 32'(keep));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_logical();
    t_arith();
    t_rotate();
    t_rotx();
    t_negative();
    t_zero();
    t_source();
    t_flags_weight();
    t_hold();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule